// File: doc/BRIEF.md
# Data Memory Target Router

This block takes one data memory access of a small 8-bit controller and decides which storage target must serve it. Five targets exist: the lower half of the internal scratch RAM, the upper half of that RAM, the special-function-register (SFR) space, an on-chip expanded RAM of 768 bytes, and the external data bus. The choice depends on the address, on the access kind (direct, indirect, or external move), and on a configuration bit that turns the on-chip expanded RAM off.

Addresses 80H to FFH are shared by two targets. A direct access there reaches the SFR space, and an indirect access there reaches the upper RAM. External moves go to the expanded RAM when it is enabled and the address is inside it. Otherwise they go to the external bus. Together the scratch RAM and the expanded RAM hold 1024 bytes. The block registers its result. One clock after the strobe it presents a one-hot target select and the address local to that target. The storage arrays use these outputs.

Top module: `dmem_route`

## Requirements
- R1: A direct (acc_type 00) or indirect (acc_type 01) access to an address whose low byte is 00H..7FH selects the lower RAM (tgt_sel bit 0).
- R2: An indirect access with low byte 80H..FFH selects the upper RAM (tgt_sel bit 1).
- R3: A direct access with low byte 80H..FFH selects the SFR space (tgt_sel bit 2).
- R4: An external move (acc_type 10) to 0000H..02FFH with xram_off = 0 selects the expanded RAM (tgt_sel bit 3).
- R5: An external move to 0300H..FFFFH with xram_off = 0 selects the external bus (tgt_sel bit 4).
- R6: With xram_off = 1, every external move selects the external bus, including addresses below 0300H.
- R7: When neither rd nor wr is high, tgt_sel and loc_addr are all zero.
- R8: tgt_sel never has more than one bit set. Exactly one bit is set after a strobed access of type 00, 01 or 10.
- R9: Access type 11 is reserved and selects no target, even with a strobe.
- R10: loc_addr is addr[6:0] for the lower and upper RAM, addr[7:0] for the SFR space, and the full address for the expanded RAM and the external bus.
- R11: Results appear on the first rising clock edge after the inputs are applied. The asynchronous active-low reset clears tgt_sel and loc_addr.
- R12: For direct and indirect accesses, addr[15:8] has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Access address |
| acc_type | input | 2 | 00 direct, 01 indirect, 10 external move, 11 reserved |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| xram_off | input | 1 | 1 disables the on-chip expanded RAM |
| tgt_sel | output | 5 | One-hot target: 0 lower, 1 upper, 2 SFR, 3 expanded RAM, 4 external |
| loc_addr | output | 16 | Address local to the selected target |

## Verification
Both outputs come from one register stage, so every result is due exactly one rising edge after its inputs. The bench drives each vector on a falling edge and lets one rising edge pass. It compares on the following falling edge, before the next vector is driven. Reset clears the outputs at once, without a clock edge. The bench checks this while the clock is still held.

// File: rtl/dmem_route_pkg.sv
package dmem_route_pkg;

  localparam logic [1:0] ACC_DIRECT   = 2'b00;
  localparam logic [1:0] ACC_INDIRECT = 2'b01;
  localparam logic [1:0] ACC_XMOVE    = 2'b10;
  localparam logic [1:0] ACC_RSVD     = 2'b11;

  localparam int TGT_N    = 5;
  localparam int TGT_LOW  = 0;
  localparam int TGT_UP   = 1;
  localparam int TGT_SFR  = 2;
  localparam int TGT_XRAM = 3;
  localparam int TGT_EXT  = 4;

  // Internal space target for the low address byte under a given access kind.
  function automatic logic [TGT_N-1:0] int_target(input logic [1:0] kind, input logic [7:0] a);
    logic [TGT_N-1:0] s;
    s = '0;
    if (!a[7])                  s[TGT_LOW] = 1'b1;
    else if (kind == ACC_INDIRECT) s[TGT_UP] = 1'b1;
    else                        s[TGT_SFR] = 1'b1;
    return s;
  endfunction

  // An external move lands on chip only when enabled and below the limit.
  function automatic logic xram_hit(input logic [15:0] a, input logic off, input int unsigned limit);
    return !off && (32'(a) < limit);
  endfunction

endpackage

// File: rtl/dmem_int_dec.sv
module dmem_int_dec
  import dmem_route_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [1:0]        kind,
  input  logic [7:0]        addr_lo,
  output logic [TGT_N-1:0]  sel,
  output logic [ADDR_W-1:0] loc
);
  always_comb begin
    sel = int_target(kind, addr_lo);
    loc = '0;
    if (sel[TGT_SFR]) loc[7:0] = addr_lo;
    else              loc[6:0] = addr_lo[6:0];
  end
endmodule

// File: rtl/dmem_ext_dec.sv
module dmem_ext_dec
  import dmem_route_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int XRAM_BYTES = 768
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              xram_off,
  output logic [TGT_N-1:0]  sel,
  output logic [ADDR_W-1:0] loc
);
  localparam int XRAM_AW = $clog2(XRAM_BYTES);

  logic on_chip;

  always_comb begin
    on_chip = xram_hit(16'(addr), xram_off, XRAM_BYTES);
    sel = '0;
    loc = addr;
    if (on_chip) begin
      sel[TGT_XRAM] = 1'b1;
      loc = '0;
      loc[XRAM_AW-1:0] = addr[XRAM_AW-1:0];
    end else begin
      sel[TGT_EXT] = 1'b1;
    end
  end
endmodule

// File: rtl/dmem_out_reg.sv
module dmem_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/dmem_route.sv
module dmem_route
  import dmem_route_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int XRAM_BYTES = 768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        acc_type,
  input  logic              rd,
  input  logic              wr,
  input  logic              xram_off,
  output logic [TGT_N-1:0]  tgt_sel,
  output logic [ADDR_W-1:0] loc_addr
);
  localparam int OUT_W = TGT_N + ADDR_W;

  logic              strobe;
  logic              int_go;
  logic              ext_go;
  logic [TGT_N-1:0]  int_sel, ext_sel, nxt_sel;
  logic [ADDR_W-1:0] int_loc, ext_loc, nxt_loc;

  assign strobe = rd | wr;
  assign int_go = strobe && (acc_type == ACC_DIRECT || acc_type == ACC_INDIRECT);
  assign ext_go = strobe && (acc_type == ACC_XMOVE);

  dmem_int_dec #(.ADDR_W(ADDR_W)) u_int (
    .kind    (acc_type),
    .addr_lo (addr[7:0]),
    .sel     (int_sel),
    .loc     (int_loc)
  );

  dmem_ext_dec #(.ADDR_W(ADDR_W), .XRAM_BYTES(XRAM_BYTES)) u_ext (
    .addr     (addr),
    .xram_off (xram_off),
    .sel      (ext_sel),
    .loc      (ext_loc)
  );

  always_comb begin
    nxt_sel = '0;
    nxt_loc = '0;
    if (int_go) begin
      nxt_sel = int_sel;
      nxt_loc = int_loc;
    end else if (ext_go) begin
      nxt_sel = ext_sel;
      nxt_loc = ext_loc;
    end
  end

  dmem_out_reg #(.W(OUT_W)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({nxt_sel, nxt_loc}),
    .q     ({tgt_sel, loc_addr})
  );
endmodule

// File: rtl/dmem_route_chk.sv
module dmem_route_chk
  import dmem_route_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int XRAM_BYTES = 768
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        acc_type,
  input logic              rd,
  input logic              wr,
  input logic              xram_off,
  input logic [TGT_N-1:0]  tgt_sel,
  input logic [ADDR_W-1:0] loc_addr
);
  logic stb;
  logic in_xram;
  assign stb     = rd | wr;
  assign in_xram = (32'(addr) < XRAM_BYTES);

  AST_LOWER_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !acc_type[1] && !addr[7]) |=> (tgt_sel == 5'b00001)); // R1
  AST_UPPER_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && acc_type == ACC_INDIRECT && addr[7]) |=> (tgt_sel == 5'b00010)); // R2
  AST_SFR_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && acc_type == ACC_DIRECT && addr[7]) |=> (tgt_sel == 5'b00100 && loc_addr == ADDR_W'($past(addr[7:0])))); // R3
  AST_XRAM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && acc_type == ACC_XMOVE && !xram_off && in_xram) |=> (tgt_sel == 5'b01000)); // R4
  AST_EXT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && acc_type == ACC_XMOVE && !in_xram) |=> (tgt_sel == 5'b10000 && loc_addr == $past(addr))); // R5
  AST_EXT_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && acc_type == ACC_XMOVE && xram_off) |=> (tgt_sel == 5'b10000)); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb) |=> (tgt_sel == '0 && loc_addr == '0)); // R7
  AST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel)); // R8
  AST_RSVD_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_type == ACC_RSVD) |=> (tgt_sel == '0)); // R9
endmodule

bind dmem_route dmem_route_chk #(.ADDR_W(ADDR_W), .XRAM_BYTES(XRAM_BYTES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .acc_type (acc_type),
  .rd       (rd),
  .wr       (wr),
  .xram_off (xram_off),
  .tgt_sel  (tgt_sel),
  .loc_addr (loc_addr)
);

// File: tb/dmem_route_tb.sv
module dmem_route_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  // {req[3:0], kind[1:0], addr[15:0], off, rd, wr, exp_sel[4:0], exp_loc[15:0]} = 46 bits
  localparam logic [45:0] VEC [NV] = '{
    {4'd1,  2'b00, 16'h0000, 1'b0, 1'b1, 1'b0, 5'b00001, 16'h0000}, // R1 direct bottom
    {4'd1,  2'b01, 16'h007F, 1'b0, 1'b0, 1'b1, 5'b00001, 16'h007F}, // R1 indirect top of lower
    {4'd3,  2'b00, 16'h0080, 1'b0, 1'b1, 1'b0, 5'b00100, 16'h0080}, // R3 direct first SFR
    {4'd3,  2'b00, 16'h00FF, 1'b0, 1'b0, 1'b1, 5'b00100, 16'h00FF}, // R3
    {4'd2,  2'b01, 16'h0080, 1'b0, 1'b1, 1'b0, 5'b00010, 16'h0000}, // R2 indirect upper, R10 offset
    {4'd2,  2'b01, 16'h00FF, 1'b0, 1'b1, 1'b1, 5'b00010, 16'h007F}, // R2
    {4'd4,  2'b10, 16'h0000, 1'b0, 1'b1, 1'b0, 5'b01000, 16'h0000}, // R4
    {4'd4,  2'b10, 16'h02FF, 1'b0, 1'b0, 1'b1, 5'b01000, 16'h02FF}, // R4 last byte
    {4'd5,  2'b10, 16'h0300, 1'b0, 1'b1, 1'b0, 5'b10000, 16'h0300}, // R5 first external
    {4'd5,  2'b10, 16'hFFFF, 1'b0, 1'b0, 1'b1, 5'b10000, 16'hFFFF}, // R5
    {4'd6,  2'b10, 16'h0005, 1'b1, 1'b1, 1'b0, 5'b10000, 16'h0005}, // R6
    {4'd6,  2'b10, 16'h02FF, 1'b1, 1'b0, 1'b1, 5'b10000, 16'h02FF}, // R6
    {4'd7,  2'b00, 16'h0010, 1'b0, 1'b0, 1'b0, 5'b00000, 16'h0000}, // R7
    {4'd7,  2'b10, 16'h0100, 1'b0, 1'b0, 1'b0, 5'b00000, 16'h0000}, // R7
    {4'd9,  2'b11, 16'h0010, 1'b0, 1'b1, 1'b0, 5'b00000, 16'h0000}, // R9
    {4'd12, 2'b00, 16'h1285, 1'b0, 1'b1, 1'b0, 5'b00100, 16'h0085}, // R12 high byte ignored
    {4'd12, 2'b01, 16'hAB3C, 1'b0, 1'b1, 1'b0, 5'b00001, 16'h003C}, // R12
    {4'd10, 2'b01, 16'hFFC1, 1'b0, 1'b0, 1'b1, 5'b00010, 16'h0041}  // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  acc_type = 2'b00;
  logic        rd = 1'b0, wr = 1'b0, xram_off = 1'b0;
  logic [4:0]  tgt_sel;
  logic [15:0] loc_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_route u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .acc_type(acc_type),
    .rd(rd), .wr(wr), .xram_off(xram_off), .tgt_sel(tgt_sel), .loc_addr(loc_addr)
  );

  task automatic check(input string req, input logic [4:0] es, input logic [15:0] el);
    n_chk++;
    if (tgt_sel !== es || loc_addr !== el) begin
      n_fail++;
      $display("FAIL %s: sel=%b loc=%h expected sel=%b loc=%h", req, tgt_sel, loc_addr, es, el);
    end
  endtask

  task automatic apply(input logic [1:0] k, input logic [15:0] a, input logic o,
                       input logic r, input logic w);
    acc_type = k; addr = a; xram_off = o; rd = r; wr = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R11 reset state with a strobe already present
    apply(2'b00, 16'h0010, 1'b0, 1'b1, 1'b0);
    check("R11 reset", 5'b0, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 first edge after reset", 5'b00001, 16'h0010);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][41:40], VEC[i][39:24], VEC[i][23], VEC[i][22], VEC[i][21]);
      check($sformatf("R%0d vector %0d", VEC[i][45:42], i), VEC[i][20:16], VEC[i][15:0]);
    end

    // R11 latency: output holds the old value before the edge
    @(negedge clk);
    acc_type = 2'b10; addr = 16'h0400; xram_off = 1'b0; rd = 1'b1; wr = 1'b0;
    #1 check("R11 no change before edge", 5'b00010, 16'h0041);
    @(posedge clk); @(negedge clk);
    check("R11 after edge", 5'b10000, 16'h0400);

    // R8 consecutive accesses with a strobe on every cycle
    apply(2'b00, 16'h00C0, 1'b0, 1'b1, 1'b1);
    check("R8 one target", 5'b00100, 16'h00C0);

    // R11 asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1 check("R11 async clear", 5'b0, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(2'b01, 16'h0099, 1'b0, 1'b1, 1'b0);
    check("R2 after reset", 5'b00010, 16'h0019);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule